// File: doc/BRIEF.md
# Clock Phase Delay Generator

This block takes a module clock that an upstream divider derives from a faster parent clock and makes two shifted copies of it: an output clock and a sample clock. Everything runs on the parent clock. The module clock enters as a level that changes only on parent-clock edges, and each derived clock is a registered copy of it.

Each copy is delayed by a programmable whole number of parent-clock periods. A delay code of zero is a special case: it gives a 180-degree inversion, not zero shift. Because the unit of shift is one parent period, the size of one step in degrees depends on the parent-to-module divide ratio. A separate input reports the current divide ratio.

Software programs two 2-bit codes through a masked register port. It reads the codes back, together with a computed phase in degrees for each derived clock. A new code only takes effect at a module-clock rising edge, so a code change cannot cut a pulse short.

Top module: `clk_phase_gen`

## Requirements
- R1: The output-clock code sits in register bits [9:8] and the sample-clock code sits in bits [21:20]. `reg_rdata` returns both codes in those positions, and every other bit reads as zero.
- R2: A write with `reg_we` high replaces only the code bits whose `reg_wmask` bit is 1. Every other code bit keeps its value, and with `reg_we` low nothing changes.
- R3: While the active code of a derived clock is 0, that clock equals the inverse of `mod_clk` as sampled one parent cycle earlier.
- R4: While the active code D is nonzero and the divide ratio N is at least 2, the derived clock equals `mod_clk` delayed by (D mod N) parent cycles, on top of the common one-cycle register latency.
- R5: A code D with D >= N wraps modulo the module period. For example, D=3 with N=2 shifts by 1 cycle, and D=2 with N=2 shifts by 0 cycles.
- R6: A programmed code becomes active only at a parent edge where `mod_clk` is seen rising (1 now, 0 on the previous edge). Until that edge, the derived clock keeps following the previous code.
- R7: One parent cycle after a register or ratio change, each phase report shows 180 for code 0. For a nonzero code D it shows D * round(360 / N), where halves round up.
- R8: When `div_ratio` is 1 (or 0), every nonzero code reports 0 degrees and code 0 still reports 180.
- R9: After reset both codes are 0, `reg_rdata` is 0, both reports are 180, and both derived clocks run as the inverted module clock without waiting for a module edge.
- R10: The two derived clocks and their reports are independent. Changing one code leaves the other clock, its code and its report untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_clk | input | 1 | Divided module clock, as a level synchronous to `clk` |
| div_ratio | input | RATIO_W | Current parent-to-module divide ratio N |
| reg_we | input | 1 | Register write strobe |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of both delay codes |
| out_clk | output | 1 | Delayed output clock |
| smp_clk | output | 1 | Delayed sample clock |
| out_phase_deg | output | 11 | Reported phase of `out_clk` in degrees |
| smp_phase_deg | output | 11 | Reported phase of `smp_clk` in degrees |

## Verification
The bench sweeps divide ratios 2 to 6 against all four codes, with the two channels given complementary codes. Each derived clock is compared with a tap of the bench's own record of `mod_clk`. This sweep separates the inversion from a real shift, and the wrapped shift from an unwrapped one. Ratio 1 is swept for the reports alone, so the 0-degree rule can be told apart from the 180-degree rule. A code written in the middle of a module period separates switching at the next rising edge from switching at once. Masked writes show whether one field leaks into the other.

// File: rtl/clk_phase_pkg.sv
package clk_phase_pkg;
  localparam int REG_W     = 32;
  localparam int CODE_W    = 2;
  localparam int MAX_D     = (1 << CODE_W) - 1;
  localparam int NCH       = 2;
  localparam int OUT_LSB   = 8;
  localparam int SMP_LSB   = 20;
  localparam int PH_W      = 11;
  localparam int FULL_TURN = 360;
  localparam int HALF_TURN = FULL_TURN / 2;

  typedef logic [CODE_W-1:0] code_t;

  // bit position of each channel's code inside the shared register
  function automatic int chan_lsb(input int ch);
    return (ch == 0) ? OUT_LSB : SMP_LSB;
  endfunction
endpackage

// File: rtl/phase_history.sv
module phase_history #(
  parameter int DEPTH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mod_clk,
  output logic [DEPTH:0] taps,
  output logic           rise
);
  logic [DEPTH:1] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DEPTH-1:1], mod_clk};
  end

  assign taps = {hist, mod_clk};
  assign rise = mod_clk & ~hist[1];
endmodule

// File: rtl/phase_tap.sv
module phase_tap import clk_phase_pkg::*; #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rise,
  input  code_t              code,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [MAX_D:0]     taps,
  output logic               clk_out,
  output logic               act_inv,
  output code_t              act_sh
);
  logic [RATIO_W-1:0] rem;

  always_comb begin
    if (ratio > RATIO_W'(1)) rem = RATIO_W'(code) % ratio;
    else                     rem = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_inv <= 1'b1;
      act_sh  <= '0;
      clk_out <= 1'b0;
    end else begin
      if (rise) begin
        act_inv <= (code == '0);
        act_sh  <= rem[CODE_W-1:0];
      end
      clk_out <= act_inv ? ~taps[0] : taps[act_sh];
    end
  end
endmodule

// File: rtl/phase_report.sv
module phase_report import clk_phase_pkg::*; #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  code_t              code,
  input  logic [RATIO_W-1:0] ratio,
  output logic [PH_W-1:0]    deg
);
  localparam int CALC_W = RATIO_W + PH_W;

  logic [CALC_W-1:0] step;
  logic [CALC_W-1:0] prod;

  always_comb begin
    if (ratio > RATIO_W'(1))
      step = (CALC_W'(FULL_TURN) + CALC_W'(ratio >> 1)) / CALC_W'(ratio);
    else
      step = '0;
    prod = step * CALC_W'(code);
  end

  always_ff @(posedge clk) begin
    if (rst)               deg <= PH_W'(HALF_TURN);
    else if (code == '0)   deg <= PH_W'(HALF_TURN);
    else                   deg <= prod[PH_W-1:0];
  end
endmodule

// File: rtl/clk_phase_gen.sv
module clk_phase_gen import clk_phase_pkg::*; #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mod_clk,
  input  logic [RATIO_W-1:0] div_ratio,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_wmask,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               out_clk,
  output logic               smp_clk,
  output logic [PH_W-1:0]    out_phase_deg,
  output logic [PH_W-1:0]    smp_phase_deg
);
  logic [MAX_D:0]  taps;
  logic            rise;
  code_t           code_q  [NCH];
  logic [NCH-1:0]  clk_vec;
  logic [NCH-1:0]  act_inv;
  code_t           act_sh  [NCH];
  logic [PH_W-1:0] deg_vec [NCH];

  phase_history #(.DEPTH(MAX_D)) u_hist (
    .clk(clk), .rst(rst), .mod_clk(mod_clk), .taps(taps), .rise(rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int L = chan_lsb(g);

    always_ff @(posedge clk) begin
      if (rst)
        code_q[g] <= '0;
      else if (reg_we)
        code_q[g] <= (code_q[g] & ~reg_wmask[L +: CODE_W]) |
                     (reg_wdata[L +: CODE_W] & reg_wmask[L +: CODE_W]);
    end

    phase_tap #(.RATIO_W(RATIO_W)) u_tap (
      .clk(clk), .rst(rst), .rise(rise), .code(code_q[g]), .ratio(div_ratio),
      .taps(taps), .clk_out(clk_vec[g]), .act_inv(act_inv[g]), .act_sh(act_sh[g])
    );

    phase_report #(.RATIO_W(RATIO_W)) u_rep (
      .clk(clk), .rst(rst), .code(code_q[g]), .ratio(div_ratio), .deg(deg_vec[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[OUT_LSB +: CODE_W] = code_q[0];
    reg_rdata[SMP_LSB +: CODE_W] = code_q[1];
  end

  assign out_clk       = clk_vec[0];
  assign smp_clk       = clk_vec[1];
  assign out_phase_deg = deg_vec[0];
  assign smp_phase_deg = deg_vec[1];
endmodule

// File: rtl/clk_phase_gen_chk.sv
module clk_phase_gen_chk import clk_phase_pkg::*; #(
  parameter int RATIO_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               mod_clk,
  input logic [RATIO_W-1:0] div_ratio,
  input logic               reg_we,
  input logic [REG_W-1:0]   reg_wmask,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               out_clk,
  input logic [PH_W-1:0]    out_phase_deg,
  input logic [NCH-1:0]     act_inv,
  input logic               rise
);
  localparam logic [REG_W-1:0] FIELD_MASK =
    (REG_W'(MAX_D) << OUT_LSB) | (REG_W'(MAX_D) << SMP_LSB);

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R1
  field_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~FIELD_MASK) == '0);

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_we || reg_wmask[OUT_LSB +: CODE_W] == '0)
      |=> reg_rdata[OUT_LSB +: CODE_W] == $past(reg_rdata[OUT_LSB +: CODE_W]));

  // R3
  invert_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(act_inv[0])) |-> out_clk == !$past(mod_clk));

  // R6
  switch_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !$stable(act_inv)) |-> $past(rise));

  // R7
  inv_report_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[OUT_LSB +: CODE_W] == '0) |=> out_phase_deg == PH_W'(HALF_TURN));

  // R8
  unit_ratio_chk: assert property (@(posedge clk) disable iff (rst)
    (div_ratio <= RATIO_W'(1) && reg_rdata[OUT_LSB +: CODE_W] != '0)
      |=> out_phase_deg == '0);
endmodule

bind clk_phase_gen clk_phase_gen_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .mod_clk(mod_clk), .div_ratio(div_ratio),
  .reg_we(reg_we), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
  .out_clk(out_clk), .out_phase_deg(out_phase_deg), .act_inv(act_inv),
  .rise(rise)
);

// File: tb/clk_phase_gen_tb.sv
module clk_phase_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_clk = 1'b0;
  logic [7:0]  div_ratio = 8'd4;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wmask = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_clk, smp_clk;
  logic [10:0] out_phase_deg, smp_phase_deg;

  int  checks = 0;
  int  errors = 0;
  int  n = 4;
  int  cnt = 0;
  bit  done = 0;
  bit  h [8];

  always #2.5 clk = ~clk;

  clk_phase_gen #(.RATIO_W(8)) u_dut (
    .clk(clk), .rst(rst), .mod_clk(mod_clk), .div_ratio(div_ratio),
    .reg_we(reg_we), .reg_wmask(reg_wmask), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_clk(out_clk), .smp_clk(smp_clk),
    .out_phase_deg(out_phase_deg), .smp_phase_deg(smp_phase_deg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one parent cycle; h[0] holds the mod_clk value seen at the edge just passed
  task automatic step();
    @(negedge clk);
    for (int i = 7; i > 0; i--) h[i] = h[i-1];
    h[0] = mod_clk;
    cnt = (cnt + 1) % n;
    mod_clk = (n >= 2) && (cnt < n / 2);
  endtask

  task automatic set_ratio(input int r);
    n = r;
    div_ratio = 8'(r);
    cnt = 0;
    mod_clk = (n >= 2);
  endtask

  task automatic wr(input logic [31:0] m, input logic [31:0] d);
    reg_we = 1'b1; reg_wmask = m; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wmask = '0; reg_wdata = '0;
  endtask

  function automatic int exp_deg(input int d, input int r);
    if (d == 0) return 180;
    if (r <= 1) return 0;
    return d * ((360 + r / 2) / r);
  endfunction

  function automatic bit exp_clk(input int d, input int r);
    if (d == 0) return !h[0];
    return h[d % r];
  endfunction

  // compare both clocks with the model over a window; one check per clock
  task automatic win(input int d_o, input int d_s, input int cycles, input string req);
    int bad_o = 0, bad_s = 0;
    bit eo = 0, es = 0, ao = 0, as_ = 0;
    for (int k = 0; k < cycles; k++) begin
      step();
      if (out_clk !== exp_clk(d_o, n)) begin bad_o++; ao = out_clk; eo = exp_clk(d_o, n); end
      if (smp_clk !== exp_clk(d_s, n)) begin bad_s++; as_ = smp_clk; es = exp_clk(d_s, n); end
    end
    chk(bad_o == 0, {req, " out_clk"}, ao, eo);
    chk(bad_s == 0, {req, " smp_clk"}, as_, es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) h[i] = 0;
    set_ratio(4);
    repeat (4) step();
    rst = 1'b0;
    step(); step();

    // R9 reset state
    chk(reg_rdata == 32'h0, "R9 rdata", reg_rdata, 0);
    chk(out_phase_deg == 11'd180, "R9 out deg", out_phase_deg, 180);
    chk(smp_phase_deg == 11'd180, "R9 smp deg", smp_phase_deg, 180);
    win(0, 0, 8, "R9 inverted after reset");

    // R1 layout, other bits read zero
    wr(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk(reg_rdata == 32'h0030_0300, "R1 layout", reg_rdata, 32'h0030_0300);
    // R2 / R10 masked writes leave the other field alone
    wr(32'h0000_0300, 32'hFFCF_FDFF);
    chk(reg_rdata == 32'h0030_0100, "R2 out field only", reg_rdata, 32'h0030_0100);
    wr(32'h0030_0000, 32'h0020_0200);
    chk(reg_rdata == 32'h0020_0100, "R10 smp field only", reg_rdata, 32'h0020_0100);
    wr(32'h0, 32'hFFFF_FFFF);
    chk(reg_rdata == 32'h0020_0100, "R2 empty mask", reg_rdata, 32'h0020_0100);

    // R3 R4 R5 R7 sweep over ratios and codes
    for (int r = 2; r <= 6; r++) begin
      set_ratio(r);
      for (int d = 0; d < 4; d++) begin
        wr(32'h0030_0300, 32'((d << 8) | ((3 - d) << 20)));
        repeat (3 * r + 2) step();
        win(d, 3 - d, 2 * r + 2, (d == 0) ? "R3" : ((d >= r) ? "R5" : "R4"));
        chk(out_phase_deg == 11'(exp_deg(d, r)), "R7 out deg", out_phase_deg, exp_deg(d, r));
        chk(smp_phase_deg == 11'(exp_deg(3 - d, r)), "R7 smp deg", smp_phase_deg, exp_deg(3 - d, r));
      end
    end

    // R8 unit ratio reports
    set_ratio(1);
    for (int d = 0; d < 4; d++) begin
      wr(32'h0030_0300, 32'((d << 8) | ((3 - d) << 20)));
      step(); step();
      chk(out_phase_deg == 11'(exp_deg(d, 1)), "R8 out deg", out_phase_deg, exp_deg(d, 1));
      chk(smp_phase_deg == 11'(exp_deg(3 - d, 1)), "R8 smp deg", smp_phase_deg, exp_deg(3 - d, 1));
    end

    // R6 code change waits for the next module rising edge
    set_ratio(6);
    wr(32'h0030_0300, 32'h0000_0100);
    repeat (20) step();
    while (!(h[0] == 1 && h[1] == 0)) step();
    wr(32'h0000_0300, 32'h0000_0300);
    begin
      int bad = 0;
      for (int k = 0; k < 3; k++) begin
        step();
        if (out_clk !== h[1]) bad++;
      end
      chk(bad == 0, "R6 old shift held", bad, 0);
    end
    repeat (8) step();
    win(3, 0, 12, "R6 new shift after edge");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule